// File: doc/BRIEF.md
# Handshaken Parallel Port Bridge

This block sits between a serial link transceiver and two independent byte-wide parallel ports. Each port uses a two-wire strobe/acknowledge handshake. The transceiver handles bit rate and packet framing. The bridge only decides when a byte moves and when each acknowledge is given.

On the send side, a peripheral places a byte on `pin_data` and raises `pin_valid`. The bridge latches the byte and offers it to the transceiver as a data packet. It raises `pin_ack` only after the far end of the link has acknowledged that packet. It lowers `pin_ack` once the peripheral has dropped `pin_valid`.

On the receive side, a byte delivered by the transceiver is put on `pout_data`, and `pout_valid` follows one cycle later. The bridge requests a link acknowledge packet only after the peripheral raises `pout_ack`. As a result, the remote sender is throttled by the local peripheral, byte by byte.

Transceiver stream rules:
- Transmit stream (`ltx_*`): once `ltx_valid` is high, it stays high and `ltx_data` stays stable until a cycle with `ltx_ready` high.
- Receive stream (`lrx_*`): a byte is taken only in a cycle where both `lrx_valid` and `lrx_ready` are high. `lrx_ready` is high only while no byte is held.
- Acknowledge request (`lack_send_valid`): it is held until `lack_send_ready` is seen high.

The parallel strobes `pin_valid` and `pout_ack` are asynchronous. Each passes through a synchroniser of `SYNC_STAGES` flops; the default is 2.

Top module: `ppb_bridge`

## Requirements
- R1: Three cycles after `pin_valid` rises, `ltx_valid` goes high with `ltx_data` equal to the byte on `pin_data`. It stays high with unchanged data until a cycle with `ltx_ready` high, and goes low after that cycle.
- R2: `pin_ack` rises one cycle after a `lack_rcvd` pulse, but only if the byte has already been handed to the transceiver. A `lack_rcvd` pulse at any other time leaves `pin_ack` low.
- R3: `pin_ack` falls three cycles after `pin_valid` falls. While `pin_valid` stays high after `pin_ack`, no new byte is offered on `ltx_valid`.
- R4: Changing `pin_data` after the byte has been latched does not change `ltx_data`.
- R5: A byte accepted on the receive stream appears on `pout_data` after the accepting edge. `pout_valid` rises one cycle later.
- R6: Three cycles after `pout_ack` rises, `pout_valid` is low and `lack_send_valid` is high. `lack_send_valid` stays high until `lack_send_ready`.
- R7: `pout_data` keeps its value after the handshake ends, until the next byte is accepted.
- R8: `lrx_ready` is low from acceptance until the acknowledge request has been taken. A byte offered in that window does not reach `pout_data`.
- R9: During reset, `pin_ack`, `pout_valid`, `ltx_valid` and `lack_send_valid` are low and `lrx_ready` is high.
- R10: A `pout_ack` still held high from an earlier handshake does not complete the next one. A fresh rising edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_data | input | DATA_W | Byte from the peripheral to send |
| pin_valid | input | 1 | Peripheral strobe: byte on pin_data is valid |
| pin_ack | output | 1 | Byte delivered and acknowledged by the far end |
| pout_data | output | DATA_W | Last byte received from the link |
| pout_valid | output | 1 | pout_data holds a byte not yet acknowledged |
| pout_ack | input | 1 | Peripheral has read pout_data |
| ltx_data | output | DATA_W | Byte offered to the transceiver |
| ltx_valid | output | 1 | ltx_data is offered |
| ltx_ready | input | 1 | Transceiver takes ltx_data |
| lack_rcvd | input | 1 | One-cycle pulse: acknowledge packet received |
| lrx_data | input | DATA_W | Byte received by the transceiver |
| lrx_valid | input | 1 | lrx_data is offered |
| lrx_ready | output | 1 | Bridge can take a received byte |
| lack_send_valid | output | 1 | Request to send an acknowledge packet |
| lack_send_ready | input | 1 | Transceiver takes the acknowledge request |

## Verification
Every result has a fixed cycle count from its cause, with the default `SYNC_STAGES` of 2:
- `ltx_valid`: three edges after `pin_valid` rises (two synchroniser flops, then the state register).
- `pin_ack` rise: one edge after the `lack_rcvd` pulse.
- `pin_ack` fall: three edges after `pin_valid` falls.
- `pout_data`: on the accepting edge.
- `pout_valid` rise: one edge after `pout_data`.
- `pout_valid` fall and `lack_send_valid` rise: three edges after `pout_ack` rises.

The bench drives and samples one nanosecond after each rising edge. It counts edges exactly, and it checks the output both at its due cycle and at the cycle before, so an early output is caught as well as a late one. The tests that check a stimulus has no effect (a stray link acknowledge, a held `pout_ack`, a byte offered while busy) observe the affected outputs for several cycles afterwards.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic [1:0] {
    IN_IDLE,
    IN_SEND,
    IN_WAIT,
    IN_DONE
  } in_state_e;

  typedef enum logic [1:0] {
    OUT_IDLE,
    OUT_SETUP,
    OUT_SHOW,
    OUT_ACK
  } out_state_e;
endpackage

// File: rtl/ppb_sync.sv
module ppb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r <= '0;
        end else begin
          for (int i = STAGES - 1; i > 0; i--) r[i] <= r[i-1];
          r[0] <= d;
        end
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ppb_in_side.sv
module ppb_in_side
  import ppb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pin_data_i,
  input  logic              pin_valid_i,
  output logic              pin_ack_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic              link_ack_i
);
  logic              v_sync;
  logic              v_prev;
  logic              v_rise;
  in_state_e         st, st_n;
  logic [DATA_W-1:0] hold_q;

  ppb_sync #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk(clk), .rst_n(rst_n), .d(pin_valid_i), .q(v_sync)
  );

  assign v_rise = v_sync && !v_prev;

  always_comb begin
    st_n = st;
    unique case (st)
      IN_IDLE: if (v_rise)      st_n = IN_SEND;
      IN_SEND: if (tx_ready_i)  st_n = IN_WAIT;
      IN_WAIT: if (link_ack_i)  st_n = IN_DONE;
      IN_DONE: if (!v_sync)     st_n = IN_IDLE;
      default:                  st_n = IN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IN_IDLE;
      v_prev <= 1'b0;
      hold_q <= '0;
    end else begin
      st     <= st_n;
      v_prev <= v_sync;
      if (st == IN_IDLE && v_rise) hold_q <= pin_data_i;
    end
  end

  assign tx_valid_o = (st == IN_SEND);
  assign tx_data_o  = hold_q;
  assign pin_ack_o  = (st == IN_DONE);

  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  assert_ack_after_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_ack_o) |-> $past(link_ack_i));

  assert_ack_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_ack_o) |-> !$past(v_sync));

  assert_no_offer_during_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ack_o |-> !tx_valid_o);
endmodule

// File: rtl/ppb_out_side.sv
module ppb_out_side
  import ppb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ack_i,
  output logic              ack_valid_o,
  input  logic              ack_ready_i
);
  logic              a_sync;
  logic              a_prev;
  logic              a_rise;
  out_state_e        st, st_n;
  logic [DATA_W-1:0] data_q;

  ppb_sync #(.STAGES(SYNC_STAGES)) u_async (
    .clk(clk), .rst_n(rst_n), .d(out_ack_i), .q(a_sync)
  );

  assign a_rise = a_sync && !a_prev;

  always_comb begin
    st_n = st;
    unique case (st)
      OUT_IDLE:  if (rx_valid_i)  st_n = OUT_SETUP;
      OUT_SETUP:                  st_n = OUT_SHOW;
      OUT_SHOW:  if (a_rise)      st_n = OUT_ACK;
      OUT_ACK:   if (ack_ready_i) st_n = OUT_IDLE;
      default:                    st_n = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= OUT_IDLE;
      a_prev <= 1'b0;
      data_q <= '0;
    end else begin
      st     <= st_n;
      a_prev <= a_sync;
      if (st == OUT_IDLE && rx_valid_i) data_q <= rx_data_i;
    end
  end

  assign rx_ready_o  = (st == OUT_IDLE);
  assign out_valid_o = (st == OUT_SHOW);
  assign ack_valid_o = (st == OUT_ACK);
  assign out_data_o  = data_q;

  assert_data_before_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $stable(out_data_o));

  assert_ack_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid_o) |-> ack_valid_o);

  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o && !ack_ready_i |=> ack_valid_o);

  assert_data_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_i && rx_ready_o) |=> $stable(out_data_o));

  assert_single_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o || ack_valid_o) |-> !rx_ready_o);
endmodule

// File: rtl/ppb_bridge.sv
module ppb_bridge
  import ppb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_valid,
  output logic              pin_ack,
  output logic [DATA_W-1:0] pout_data,
  output logic              pout_valid,
  input  logic              pout_ack,
  output logic [DATA_W-1:0] ltx_data,
  output logic              ltx_valid,
  input  logic              ltx_ready,
  input  logic              lack_rcvd,
  input  logic [DATA_W-1:0] lrx_data,
  input  logic              lrx_valid,
  output logic              lrx_ready,
  output logic              lack_send_valid,
  input  logic              lack_send_ready
);
  ppb_in_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n),
    .pin_data_i(pin_data), .pin_valid_i(pin_valid), .pin_ack_o(pin_ack),
    .tx_data_o(ltx_data), .tx_valid_o(ltx_valid), .tx_ready_i(ltx_ready),
    .link_ack_i(lack_rcvd)
  );

  ppb_out_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_out (
    .clk(clk), .rst_n(rst_n),
    .rx_data_i(lrx_data), .rx_valid_i(lrx_valid), .rx_ready_o(lrx_ready),
    .out_data_o(pout_data), .out_valid_o(pout_valid), .out_ack_i(pout_ack),
    .ack_valid_o(lack_send_valid), .ack_ready_i(lack_send_ready)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> !pin_ack && !pout_valid && !ltx_valid && !lack_send_valid);
endmodule

// File: tb/ppb_bridge_tb.sv
module ppb_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_data = '0;
  logic       pin_valid = 1'b0;
  logic       pin_ack;
  logic [7:0] pout_data;
  logic       pout_valid;
  logic       pout_ack = 1'b0;
  logic [7:0] ltx_data;
  logic       ltx_valid;
  logic       ltx_ready = 1'b0;
  logic       lack_rcvd = 1'b0;
  logic [7:0] lrx_data = '0;
  logic       lrx_valid = 1'b0;
  logic       lrx_ready;
  logic       lack_send_valid;
  logic       lack_send_ready = 1'b0;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ppb_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .pin_data(pin_data), .pin_valid(pin_valid), .pin_ack(pin_ack),
    .pout_data(pout_data), .pout_valid(pout_valid), .pout_ack(pout_ack),
    .ltx_data(ltx_data), .ltx_valid(ltx_valid), .ltx_ready(ltx_ready),
    .lack_rcvd(lack_rcvd),
    .lrx_data(lrx_data), .lrx_valid(lrx_valid), .lrx_ready(lrx_ready),
    .lack_send_valid(lack_send_valid), .lack_send_ready(lack_send_ready)
  );

  // {send byte, transmit stall cycles, receive byte}
  localparam logic [23:0] VEC [0:5] = '{
    24'h5A_00_C3, 24'h00_02_FF, 24'hFF_05_00,
    24'hA5_01_3C, 24'h81_00_7E, 24'h1E_03_E1
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic in_txn(input logic [7:0] b, input int stall);
    pin_data  = b;
    pin_valid = 1'b1;
    repeat (2) step();
    chk(ltx_valid == 1'b0, "R1 early offer", ltx_valid, 0);
    step();
    chk(ltx_valid == 1'b1 && ltx_data == b, "R1 offer", ltx_data, b);
    pin_data = ~b;  // R4
    for (int i = 0; i < stall; i++) step();
    chk(ltx_valid == 1'b1 && ltx_data == b, "R4 latched byte", ltx_data, b);
    ltx_ready = 1'b1;
    step();
    ltx_ready = 1'b0;
    chk(ltx_valid == 1'b0 && pin_ack == 1'b0, "R1 offer ends", {ltx_valid, pin_ack}, 0);
    lack_rcvd = 1'b1;
    step();
    lack_rcvd = 1'b0;
    chk(pin_ack == 1'b1, "R2 ack after link ack", pin_ack, 1);
    repeat (4) step();
    chk(pin_ack == 1'b1 && ltx_valid == 1'b0, "R3 no new byte", {pin_ack, ltx_valid}, 2);
    pin_valid = 1'b0;
    repeat (2) step();
    chk(pin_ack == 1'b1, "R3 early drop", pin_ack, 1);
    step();
    chk(pin_ack == 1'b0, "R3 ack drop", pin_ack, 0);
  endtask

  task automatic out_txn(input logic [7:0] b);
    chk(lrx_ready == 1'b1, "R8 ready idle", lrx_ready, 1);
    lrx_data  = b;
    lrx_valid = 1'b1;
    step();
    lrx_valid = 1'b0;
    chk(pout_data == b && pout_valid == 1'b0, "R5 data first", pout_data, b);
    step();
    chk(pout_valid == 1'b1, "R5 valid next", pout_valid, 1);
    lrx_data  = ~b;
    lrx_valid = 1'b1;
    chk(lrx_ready == 1'b0, "R8 ready busy", lrx_ready, 0);
    step();
    lrx_valid = 1'b0;
    chk(pout_data == b, "R8 busy byte dropped", pout_data, b);
    pout_ack = 1'b1;
    repeat (2) step();
    chk(pout_valid == 1'b1, "R6 early drop", pout_valid, 1);
    step();
    chk(pout_valid == 1'b0 && lack_send_valid == 1'b1, "R6 ack request",
        {pout_valid, lack_send_valid}, 1);
    step();
    chk(lack_send_valid == 1'b1, "R6 ack held", lack_send_valid, 1);
    lack_send_ready = 1'b1;
    step();
    lack_send_ready = 1'b0;
    chk(lack_send_valid == 1'b0 && lrx_ready == 1'b1, "R6 ack taken",
        {lack_send_valid, lrx_ready}, 1);
    chk(pout_data == b, "R7 data kept", pout_data, b);
    pout_ack = 1'b0;
    repeat (3) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk(!pin_ack && !pout_valid && !ltx_valid && !lack_send_valid && lrx_ready,
        "R9 reset state", {pin_ack, pout_valid, ltx_valid, lack_send_valid, lrx_ready}, 1);
    rst_n = 1'b1;
    step();

    // R2: stray link acknowledge while idle
    lack_rcvd = 1'b1;
    step();
    lack_rcvd = 1'b0;
    repeat (2) step();
    chk(pin_ack == 1'b0, "R2 stray link ack", pin_ack, 0);

    // R2: link acknowledge while byte still pending at transceiver
    pin_data  = 8'h42;
    pin_valid = 1'b1;
    repeat (3) step();
    lack_rcvd = 1'b1;
    step();
    lack_rcvd = 1'b0;
    step();
    chk(pin_ack == 1'b0 && ltx_valid == 1'b1, "R2 ack before handoff", {pin_ack, ltx_valid}, 1);
    ltx_ready = 1'b1;
    step();
    ltx_ready = 1'b0;
    lack_rcvd = 1'b1;
    step();
    lack_rcvd = 1'b0;
    chk(pin_ack == 1'b1, "R2 ack after handoff", pin_ack, 1);
    pin_valid = 1'b0;
    repeat (3) step();

    for (int k = 0; k < 6; k++) begin
      in_txn(VEC[k][23:16], int'(VEC[k][15:8]));
      out_txn(VEC[k][7:0]);
    end

    // R10: held pout_ack does not complete the next byte
    lrx_data  = 8'h3C;
    lrx_valid = 1'b1;
    step();
    lrx_valid = 1'b0;
    step();
    pout_ack = 1'b1;
    repeat (3) step();
    lack_send_ready = 1'b1;
    step();
    lack_send_ready = 1'b0;
    lrx_data  = 8'h99;
    lrx_valid = 1'b1;
    step();
    lrx_valid = 1'b0;
    step();
    chk(pout_valid == 1'b1 && pout_data == 8'h99, "R5 second byte", pout_data, 8'h99);
    repeat (6) step();
    chk(pout_valid == 1'b1 && lack_send_valid == 1'b0, "R10 held ack ignored",
        {pout_valid, lack_send_valid}, 2);
    pout_ack = 1'b0;
    repeat (3) step();
    chk(pout_valid == 1'b1, "R10 still waiting", pout_valid, 1);
    pout_ack = 1'b1;
    repeat (3) step();
    chk(pout_valid == 1'b0 && lack_send_valid == 1'b1, "R10 fresh edge acks",
        {pout_valid, lack_send_valid}, 1);
    lack_send_ready = 1'b1;
    step();
    lack_send_ready = 1'b0;
    pout_ack = 1'b0;
    repeat (10) step();
    chk(pout_data == 8'h99, "R7 data kept idle", pout_data, 8'h99);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule